// File: doc/BRIEF.md
# Search Step Unit for a Single-Wire Device Bus

This block carries out one branch decision of the identity search on a single-wire device bus. On each step it asks a slot engine for two read slots and one write slot, in that order. The first read returns the identifier bit that every device still taking part puts on the bus. The second read returns the complement of that bit. From these two bits and a preferred direction supplied by the caller, the block picks the branch to follow. It then writes that branch back onto the bus, so that devices on the other branch drop out of the search.

If both reads come back 1, no device answered. The block then issues no write and reports a status that tells the caller to restart the search. The caller runs the 64-step loop and keeps the discrepancy bookkeeping. To run a step, it hands in a command with the preferred direction and gets back a one-cycle done pulse together with a 3-bit status.

The command input is a valid/ready channel. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only while the unit is idle, so a caller that holds `cmd_valid` high during a step is simply held off. The slot engine side is a request/acknowledge pair with exactly one request outstanding at a time.

Top module: `rom_search_step`

## Requirements
- R1: Each step requests two read slots (`slot_wr`=0) and then at most one write slot (`slot_wr`=1). The first read is the identifier bit and the second read is its complement. No read follows the write within a step.
- R2: The 3-bit status packs the first read in bit 0, the second read in bit 1 and the direction taken in bit 2. The only values it can take are 0, 2, 3, 4 and 5.
- R3: If both reads return 1, the status is 3 (binary 011), no write slot is requested, and done follows the second acknowledge.
- R4: If both reads return 0, the preferred direction is written. The status is 4 when that direction is 1 and 0 when it is 0.
- R5: If exactly one read returns 1, the identifier bit is written as the direction. The status is 5 when the identifier bit is 1 and 2 when it is 0.
- R6: `step_done` is high for exactly one cycle per step. `step_status` changes only on the cycle done rises and then holds its value until the next step completes.
- R7: `cmd_ready` is high only while idle. A command offered while a step is in progress is not taken and starts no extra slots.
- R8: `slot_req` stays high, with `slot_wr` and `slot_wbit` stable, until `slot_ack`. It drops in the cycle after the acknowledge and stays low for at least one cycle before the next request.
- R9: After reset, or after a reset during a step, the unit is idle with `cmd_ready`=1, `slot_req`=0, `step_done`=0 and `step_status`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Step command offered |
| cmd_ready | output | 1 | Unit idle; command taken when valid and ready are both high |
| cmd_pref_dir | input | 1 | Direction to take when devices disagree |
| slot_req | output | 1 | Slot request to the slot engine, held until acknowledged |
| slot_wr | output | 1 | Slot kind: 0 read slot, 1 write slot |
| slot_wbit | output | 1 | Bit to send in a write slot |
| slot_ack | input | 1 | Slot engine finished the requested slot (one cycle) |
| slot_rbit | input | 1 | Bus level sampled by a read slot, valid with `slot_ack` |
| step_done | output | 1 | One-cycle pulse at the end of a step |
| step_status | output | 3 | Packed step result: bit 0 id, bit 1 complement, bit 2 direction |

## Verification
A command is taken on edge E0. Each slot then takes 2+L edges from the start of its phase, where L is the number of idle cycles the slot engine waits before it acknowledges. So `step_done` is visible after edge E0+6+3L for a step that writes, and after E0+4+2L for a restart step. The status is loaded on that same edge. The bench drives its inputs and samples every output at the falling edge. It counts rising edges from acceptance and compares the count at which done appears against these formulas. Status, slot order and gap checks are made at that cycle, and again a few idle cycles later.

// File: rtl/rom_search_pkg.sv
package rom_search_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_READ_ID,
    PH_READ_CMP,
    PH_WRITE_DIR,
    PH_FINISH
  } step_phase_e;

  // Packed so that bit 0 = id, bit 1 = complement, bit 2 = direction
  typedef struct packed {
    logic dir;
    logic cmp;
    logic id;
  } step_status_t;

  localparam int STATUS_W = $bits(step_status_t);

endpackage

// File: rtl/rom_search_decide.sv
module rom_search_decide
  import rom_search_pkg::*;
(
  input  logic         id_bit,
  input  logic         cmp_bit,
  input  logic         pref_dir,
  output logic         restart,
  output logic         dir,
  output step_status_t status
);

  logic disagree;

  always_comb begin
    restart  = id_bit & cmp_bit;
    disagree = ~id_bit & ~cmp_bit;
    dir      = disagree ? pref_dir : id_bit;
    if (restart) begin
      status = '{dir: 1'b0, cmp: 1'b1, id: 1'b1};
    end else begin
      status = '{dir: dir, cmp: cmp_bit, id: id_bit};
    end
  end

endmodule

// File: rtl/rom_search_slot_port.sv
module rom_search_slot_port (
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  input  logic want_wr,
  input  logic want_wbit,
  input  logic slot_ack,
  output logic slot_req,
  output logic slot_wr,
  output logic slot_wbit,
  output logic fire
);

  logic req_q, wr_q, wbit_q;

  assign fire      = req_q & slot_ack;
  assign slot_req  = req_q;
  assign slot_wr   = wr_q;
  assign slot_wbit = wbit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      wr_q   <= 1'b0;
      wbit_q <= 1'b0;
    end else if (fire) begin
      req_q <= 1'b0;
    end else if (want && !req_q) begin
      req_q  <= 1'b1;
      wr_q   <= want_wr;
      wbit_q <= want_wbit;
    end
  end

endmodule

// File: rtl/rom_search_ctrl.sv
module rom_search_ctrl
  import rom_search_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  input  logic         cmd_pref_dir,
  output logic         cmd_ready,
  input  logic         fire,
  input  logic         slot_rbit,
  input  logic         dec_restart,
  input  logic         dec_dir,
  input  step_status_t dec_status,
  output logic         id_q,
  output logic         pref_q,
  output logic         want,
  output logic         want_wr,
  output logic         want_wbit,
  output logic         step_done,
  output step_status_t status_q
);

  step_phase_e  phase_q;
  step_status_t pend_q;
  logic         dir_q;

  assign cmd_ready = (phase_q == PH_IDLE);
  assign step_done = (phase_q == PH_FINISH);
  assign want      = (phase_q == PH_READ_ID) || (phase_q == PH_READ_CMP) ||
                     (phase_q == PH_WRITE_DIR);
  assign want_wr   = (phase_q == PH_WRITE_DIR);
  assign want_wbit = dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      id_q     <= 1'b0;
      pref_q   <= 1'b0;
      dir_q    <= 1'b0;
      pend_q   <= '0;
      status_q <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (cmd_valid) begin
            pref_q  <= cmd_pref_dir;
            phase_q <= PH_READ_ID;
          end
        end
        PH_READ_ID: begin
          if (fire) begin
            id_q    <= slot_rbit;
            phase_q <= PH_READ_CMP;
          end
        end
        PH_READ_CMP: begin
          if (fire) begin
            dir_q  <= dec_dir;
            pend_q <= dec_status;
            if (dec_restart) begin
              status_q <= dec_status;
              phase_q  <= PH_FINISH;
            end else begin
              phase_q <= PH_WRITE_DIR;
            end
          end
        end
        PH_WRITE_DIR: begin
          if (fire) begin
            status_q <= pend_q;
            phase_q  <= PH_FINISH;
          end
        end
        PH_FINISH: phase_q <= PH_IDLE;
        default:   phase_q <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rom_search_step.sv
module rom_search_step
  import rom_search_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic                cmd_pref_dir,
  output logic                slot_req,
  output logic                slot_wr,
  output logic                slot_wbit,
  input  logic                slot_ack,
  input  logic                slot_rbit,
  output logic                step_done,
  output logic [STATUS_W-1:0] step_status
);

  logic         fire, want, want_wr, want_wbit;
  logic         id_q, pref_q;
  logic         dec_restart, dec_dir;
  step_status_t dec_status, status_q;

  rom_search_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_pref_dir (cmd_pref_dir),
    .cmd_ready    (cmd_ready),
    .fire         (fire),
    .slot_rbit    (slot_rbit),
    .dec_restart  (dec_restart),
    .dec_dir      (dec_dir),
    .dec_status   (dec_status),
    .id_q         (id_q),
    .pref_q       (pref_q),
    .want         (want),
    .want_wr      (want_wr),
    .want_wbit    (want_wbit),
    .step_done    (step_done),
    .status_q     (status_q)
  );

  rom_search_decide u_decide (
    .id_bit   (id_q),
    .cmp_bit  (slot_rbit),
    .pref_dir (pref_q),
    .restart  (dec_restart),
    .dir      (dec_dir),
    .status   (dec_status)
  );

  rom_search_slot_port u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .want      (want),
    .want_wr   (want_wr),
    .want_wbit (want_wbit),
    .slot_ack  (slot_ack),
    .slot_req  (slot_req),
    .slot_wr   (slot_wr),
    .slot_wbit (slot_wbit),
    .fire      (fire)
  );

  assign step_status = status_q;

endmodule

// File: rtl/rom_search_step_chk.sv
module rom_search_step_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_ready,
  input logic       slot_req,
  input logic       slot_wr,
  input logic       slot_wbit,
  input logic       slot_ack,
  input logic       step_done,
  input logic [2:0] step_status
);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    slot_req && !slot_ack |=> slot_req); // R8
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    slot_req && slot_ack |=> !slot_req); // R8
  AST_SLOT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    slot_req && !slot_ack |=> $stable(slot_wr) && $stable(slot_wbit)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    step_done |=> !step_done); // R6
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step_done |-> $stable(step_status)); // R6
  AST_BUSY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    step_done |-> !cmd_ready && !slot_req); // R7
  AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    step_done |-> (step_status != 3'd1) && (step_status != 3'd6) &&
                  (step_status != 3'd7)); // R2
  AST_SINGLE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    step_done && (step_status[0] != step_status[1]) |->
      step_status[2] == step_status[0]); // R5

endmodule

bind rom_search_step rom_search_step_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_ready   (cmd_ready),
  .slot_req    (slot_req),
  .slot_wr     (slot_wr),
  .slot_wbit   (slot_wbit),
  .slot_ack    (slot_ack),
  .step_done   (step_done),
  .step_status (step_status)
);

// File: tb/rom_search_step_bench.sv
module rom_search_step_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_pref_dir = 1'b0;
  logic       slot_ack;
  logic       slot_rbit;
  logic       cmd_ready, slot_req, slot_wr, slot_wbit, step_done;
  logic [2:0] step_status;

  int n_checks = 0;
  int n_fail = 0;

  // slot engine model state
  logic id_v = 1'b0, cmp_v = 1'b0;
  int   lat = 0;
  int   rd_cnt = 0, wr_cnt = 0, order_err = 0, gap_err = 0, kind_err = 0;
  logic wbit_seen = 1'b0;

  always #10 clk = ~clk;

  rom_search_step u_rom_search_step (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_ready    (cmd_ready),
    .cmd_pref_dir (cmd_pref_dir),
    .slot_req     (slot_req),
    .slot_wr      (slot_wr),
    .slot_wbit    (slot_wbit),
    .slot_ack     (slot_ack),
    .slot_rbit    (slot_rbit),
    .step_done    (step_done),
    .step_status  (step_status)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // Slot engine: acknowledges after lat idle falling edges
  initial begin
    int   waited;
    logic kind0;
    waited = 0;
    kind0  = 1'b0;
    slot_ack  = 1'b0;
    slot_rbit = 1'b0;
    forever begin
      @(negedge clk);
      if (slot_ack) begin
        slot_ack = 1'b0;
        if (slot_req) gap_err++;
      end else if (slot_req) begin
        if (waited == 0) kind0 = slot_wr;
        if (slot_wr != kind0) kind_err++;
        if (waited < lat) begin
          waited++;
        end else begin
          waited   = 0;
          slot_ack = 1'b1;
          if (slot_wr) begin
            if (rd_cnt != 2) order_err++;
            wr_cnt++;
            wbit_seen = slot_wbit;
            slot_rbit = 1'b0;
          end else begin
            if (wr_cnt != 0) order_err++;
            slot_rbit = (rd_cnt == 0) ? id_v : cmp_v;
            rd_cnt++;
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=expired expected=finished");
    finish_run();
  end

  // {id, cmp, pref, lat[1:0], status[2:0], write, wbit}
  localparam logic [9:0] VEC [8] = '{
    10'b0_0_0_00_000_1_0,
    10'b0_0_1_01_100_1_1,
    10'b0_1_0_10_010_1_0,
    10'b0_1_1_11_010_1_0,
    10'b1_0_0_00_101_1_1,
    10'b1_0_1_10_101_1_1,
    10'b1_1_0_01_011_0_0,
    10'b1_1_1_11_011_0_0
  };

  task automatic clear_log();
    rd_cnt = 0; wr_cnt = 0; order_err = 0; wbit_seen = 1'b0;
  endtask

  // Returns rising edges from acceptance until done is seen
  task automatic run_step(input logic idb, input logic cmpb, input logic pref,
                          input int l, input bit hold_valid, output int edges);
    id_v = idb; cmp_v = cmpb; lat = l;
    clear_log();
    cmd_pref_dir = pref;
    cmd_valid    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    if (!hold_valid) cmd_valid = 1'b0;
    edges = 0;
    while (!step_done && edges < 200) begin
      if (hold_valid && edges == 2) check("R7 ready low while busy", cmd_ready, 0);
      @(posedge clk);
      edges++;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
  endtask

  initial begin
    int edges;
    repeat (3) @(negedge clk);
    check("R9 reset ready", cmd_ready, 1);
    check("R9 reset req", slot_req, 0);
    check("R9 reset done", step_done, 0);
    check("R9 reset status", step_status, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      logic idb, cmpb, pref, wr, wb;
      int   l, st, exp_edges;
      string tag;
      {idb, cmpb, pref} = VEC[i][9:7];
      l  = int'(VEC[i][6:5]);
      st = int'(VEC[i][4:2]);
      wr = VEC[i][1];
      wb = VEC[i][0];
      if (idb && cmpb)        tag = "R3";
      else if (!idb && !cmpb) tag = "R4";
      else                    tag = "R5";
      exp_edges = wr ? 6 + 3 * l : 4 + 2 * l;
      run_step(idb, cmpb, pref, l, 1'b0, edges);
      check({tag, " done timing"}, edges, exp_edges);
      check({tag, " status"}, step_status, st);
      check("R2 status id bit0", step_status[0], idb);
      check("R1 two reads", rd_cnt, 2);
      check({tag, " write count"}, wr_cnt, wr ? 1 : 0);
      if (wr) check({tag, " written bit"}, wbit_seen, wb);
      check("R1 order", order_err, 0);
      @(negedge clk);
      check("R6 done one cycle", step_done, 0);
      check("R7 ready after step", cmd_ready, 1);
      repeat (3) @(negedge clk);
      check("R6 status held", step_status, st);
    end
    check("R8 gap after ack", gap_err, 0);
    check("R8 kind stable", kind_err, 0);

    // R7: valid held high throughout a step starts nothing more
    run_step(1'b0, 1'b0, 1'b1, 1, 1'b1, edges);
    check("R7 held-valid status", step_status, 4);
    repeat (5) @(negedge clk);
    check("R7 no extra reads", rd_cnt, 2);
    check("R7 no extra write", wr_cnt, 1);
    check("R7 idle again", cmd_ready, 1);

    // R9: reset in the middle of a step
    id_v = 1'b1; cmp_v = 1'b0; lat = 3;
    clear_log();
    cmd_pref_dir = 1'b0;
    cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 midstep ready", cmd_ready, 1);
    check("R9 midstep req", slot_req, 0);
    check("R9 midstep status", step_status, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 stays idle", slot_req, 0);
    check("R9 no done", step_done, 0);

    // R6: a following step after restart reloads status
    run_step(1'b0, 1'b1, 1'b1, 0, 1'b0, edges);
    check("R5 status after reset", step_status, 2);
    check("R6 timing after reset", edges, 6);

    finish_run();
  end

endmodule